// File: doc/BRIEF.md
# Packet Crossbar Request Router

This block is a small on-chip switch joining a set of requester-side outbound ports to a set of device-side inbound ports. Each outbound port offers one packet at a time: a two-bit kind code, an address and a data word. The router finds the packet's destination from a small table of address windows, each window also naming which packet kinds it applies to. Where several requesters want the same inbound port in one cycle, it picks one by fixed rank. The chosen packet crosses into the destination's output register at the next clock edge.

Request, write-data and read-response packets all travel over the same port. A write-data packet is not looked up by address. It follows the destination fixed by the most recent granted request from the same requester, so a write burst stays with its target. An address that falls in no enabled window, or whose kind the window does not accept, goes to a default port. A requester that is not granted keeps its packet on its port until it is.

Top module: `pkt_xbar`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every inbound valid output is low.
- R2: A request (kind 00) or response (kind 10) packet goes to the destination of the lowest-numbered window that is enabled, accepts the packet's kind (window mask bit 0 = kind 00, bit 1 = kind 01, bit 2 = kind 10) and satisfies base <= address <= limit, with both bounds inclusive.
- R3: A packet that matches no window, or carries the reserved kind 11, is routed to port DEF_PORT (3 by default).
- R4: An outbound port is granted (ro_ready high) only while it is valid and its destination's ri_avail is high; an ungranted packet is not transferred.
- R5: Among valid requesters that target the same destination in one cycle, the lowest-numbered one is the only one that can be granted.
- R6: A packet granted in a cycle appears at the next rising edge on the destination's inbound lane, with ri_valid high for exactly that one cycle and ri_src giving the requester's number.
- R7: A write-data packet (kind 01) ignores its address and goes to the destination of the same requester's last granted kind-00 packet; before any such grant that destination is DEF_PORT.
- R8: Kind, address and data reach the inbound lane unchanged, for all three packet kinds.
- R9: Requesters that target distinct available destinations are all granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_en | input | ND | Window enable, one bit per window |
| desc_base | input | ND*AW | Inclusive lower address bound per window |
| desc_limit | input | ND*AW | Inclusive upper address bound per window |
| desc_tmask | input | ND*3 | Packet kinds each window accepts |
| desc_dst | input | ND*PW | Destination port per window |
| ro_valid | input | NP | Outbound packet present, per requester |
| ro_type | input | NP*2 | Packet kind per requester (00 request, 01 write data, 10 response) |
| ro_addr | input | NP*AW | Packet address per requester |
| ro_data | input | NP*DW | Packet data per requester |
| ro_ready | output | NP | Grant: packet taken at this edge |
| ri_avail | input | NP | Destination can accept a packet this cycle |
| ri_valid | output | NP | Inbound packet present, one cycle per transfer |
| ri_type | output | NP*2 | Delivered packet kind |
| ri_addr | output | NP*AW | Delivered address |
| ri_data | output | NP*DW | Delivered data |
| ri_src | output | NP*PW | Requester that sent the delivered packet |

## Verification
On every cycle the assertions check that a grant goes only to a valid requester whose destination is available, that no higher-numbered requester wins a destination that a lower-numbered valid one also wants, and that each inbound pulse matches a grant one edge earlier with its kind, address and data intact. Whether the destination itself is right, meaning the lowest-window choice across overlaps, the kind masks, the default port and the write-data follow-on, can only be shown by the bench, whose model works out the destination independently from the window table. The bench also shows held packets waiting out a busy destination, and grants rotating through contending requesters in rank order.

// File: rtl/pkt_xbar.sv
module pkt_xbar #(
  parameter int NP = 4,
  parameter int ND = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DEF_PORT = 3,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ND-1:0]    desc_en,
  input  logic [ND*AW-1:0] desc_base,
  input  logic [ND*AW-1:0] desc_limit,
  input  logic [ND*3-1:0]  desc_tmask,
  input  logic [ND*PW-1:0] desc_dst,
  input  logic [NP-1:0]    ro_valid,
  input  logic [NP*2-1:0]  ro_type,
  input  logic [NP*AW-1:0] ro_addr,
  input  logic [NP*DW-1:0] ro_data,
  output logic [NP-1:0]    ro_ready,
  input  logic [NP-1:0]    ri_avail,
  output logic [NP-1:0]    ri_valid,
  output logic [NP*2-1:0]  ri_type,
  output logic [NP*AW-1:0] ri_addr,
  output logic [NP*DW-1:0] ri_data,
  output logic [NP*PW-1:0] ri_src
);

  logic [NP*PW-1:0] dst;
  logic [NP*PW-1:0] last_dst;
  logic [NP-1:0]    gnt;

  for (genvar i = 0; i < NP; i++) begin : g_req
    logic [1:0]    ty;
    logic [AW-1:0] ad;
    logic [PW-1:0] d, lq;
    assign ty = ro_type[i*2 +: 2];
    assign ad = ro_addr[i*AW +: AW];

    always_comb begin
      d = PW'(DEF_PORT);
      for (int k = ND - 1; k >= 0; k--)
        if (desc_en[k] && ty != 2'b11 && desc_tmask[k*3 + int'(ty)] &&
            ad >= desc_base[k*AW +: AW] && ad <= desc_limit[k*AW +: AW])
          d = desc_dst[k*PW +: PW];
      if (ty == 2'b01) d = lq;
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lq <= PW'(DEF_PORT);
      else if (gnt[i] && ty == 2'b00) lq <= d;

    assign dst[i*PW +: PW]      = d;
    assign last_dst[i*PW +: PW] = lq;
  end

  always_comb begin
    logic [NP-1:0] taken;
    gnt   = '0;
    taken = '0;
    for (int i = 0; i < NP; i++)
      if (ro_valid[i]) begin
        if (ri_avail[dst[i*PW +: PW]] && !taken[dst[i*PW +: PW]]) gnt[i] = 1'b1;
        taken[dst[i*PW +: PW]] = 1'b1;
      end
  end

  assign ro_ready = gnt;

  for (genvar j = 0; j < NP; j++) begin : g_dst
    logic          hit, v_q;
    logic [PW-1:0] src, s_q;
    logic [1:0]    t_q;
    logic [AW-1:0] a_q;
    logic [DW-1:0] d_q;

    always_comb begin
      hit = 1'b0;
      src = '0;
      for (int i = 0; i < NP; i++)
        if (gnt[i] && dst[i*PW +: PW] == PW'(j)) begin
          hit = 1'b1;
          src = PW'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        v_q <= 1'b0;
        s_q <= '0;
        t_q <= '0;
        a_q <= '0;
        d_q <= '0;
      end else begin
        v_q <= hit;
        if (hit) begin
          s_q <= src;
          t_q <= ro_type[src*2 +: 2];
          a_q <= ro_addr[src*AW +: AW];
          d_q <= ro_data[src*DW +: DW];
        end
      end

    assign ri_valid[j]         = v_q;
    assign ri_src[j*PW +: PW]  = s_q;
    assign ri_type[j*2 +: 2]   = t_q;
    assign ri_addr[j*AW +: AW] = a_q;
    assign ri_data[j*DW +: DW] = d_q;
  end

endmodule

// File: rtl/pkt_xbar_chk.sv
module pkt_xbar_chk #(
  parameter int NP = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int PW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NP-1:0]    ro_valid,
  input logic [NP-1:0]    ro_ready,
  input logic [NP-1:0]    ri_avail,
  input logic [NP*PW-1:0] dst,
  input logic [NP*2-1:0]  ro_type,
  input logic [NP*AW-1:0] ro_addr,
  input logic [NP*DW-1:0] ro_data,
  input logic [NP-1:0]    ri_valid,
  input logic [NP*2-1:0]  ri_type,
  input logic [NP*AW-1:0] ri_addr,
  input logic [NP*DW-1:0] ri_data,
  input logic [NP*PW-1:0] ri_src
);

  logic             armed;
  logic [NP-1:0]    p_ready;
  logic [NP*PW-1:0] p_dst;
  logic [NP*2-1:0]  p_type;
  logic [NP*AW-1:0] p_addr;
  logic [NP*DW-1:0] p_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else armed <= 1'b1;

  always_ff @(posedge clk) begin
    p_ready <= ro_ready;
    p_dst   <= dst;
    p_type  <= ro_type;
    p_addr  <= ro_addr;
    p_data  <= ro_data;
  end

  assert_pulse_count_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $countones(ri_valid) == $countones(p_ready));

  for (genvar i = 0; i < NP; i++) begin : g_src
    assert_grant_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ro_ready[i] |-> (ro_valid[i] && ri_avail[dst[i*PW +: PW]]));
    for (genvar k = 0; k < i; k++) begin : g_hi
      assert_rank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ro_ready[i] && ro_valid[k] && dst[k*PW +: PW] == dst[i*PW +: PW]));
    end
  end

  for (genvar j = 0; j < NP; j++) begin : g_lane
    logic [PW-1:0] sj;
    assign sj = ri_src[j*PW +: PW];
    assert_lane_origin_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ri_valid[j] |-> (p_ready[sj] && p_dst[sj*PW +: PW] == PW'(j)));
    assert_payload_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ri_valid[j] |-> (ri_type[j*2 +: 2] == p_type[sj*2 +: 2] &&
                       ri_addr[j*AW +: AW] == p_addr[sj*AW +: AW] &&
                       ri_data[j*DW +: DW] == p_data[sj*DW +: DW]));
  end

endmodule

bind pkt_xbar pkt_xbar_chk #(.NP(NP), .AW(AW), .DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ro_valid(ro_valid), .ro_ready(ro_ready),
  .ri_avail(ri_avail), .dst(dst), .ro_type(ro_type), .ro_addr(ro_addr),
  .ro_data(ro_data), .ri_valid(ri_valid), .ri_type(ri_type),
  .ri_addr(ri_addr), .ri_data(ri_data), .ri_src(ri_src)
);

// File: tb/pkt_xbar_tb.sv
`timescale 1ns/1ps
module pkt_xbar_tb;
  localparam int NP = 4, ND = 4, AW = 32, DW = 32, DEF = 3, PW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [ND-1:0]    desc_en;
  logic [ND*AW-1:0] desc_base, desc_limit;
  logic [ND*3-1:0]  desc_tmask;
  logic [ND*PW-1:0] desc_dst;
  logic [NP-1:0]    ro_valid, ro_ready, ri_avail, ri_valid;
  logic [NP*2-1:0]  ro_type, ri_type;
  logic [NP*AW-1:0] ro_addr, ri_addr;
  logic [NP*DW-1:0] ro_data, ri_data;
  logic [NP*PW-1:0] ri_src;

  logic          w_en[ND];
  logic [31:0]   w_lo[ND], w_hi[ND];
  logic [2:0]    w_mk[ND];
  int            w_ds[ND];
  logic          pv[NP];
  logic [1:0]    pt[NP];
  logic [31:0]   pa[NP], pd[NP];
  logic          av[NP];

  always_comb begin
    for (int k = 0; k < ND; k++) begin
      desc_en[k] = w_en[k];
      desc_base[k*AW +: AW] = w_lo[k];
      desc_limit[k*AW +: AW] = w_hi[k];
      desc_tmask[k*3 +: 3] = w_mk[k];
      desc_dst[k*PW +: PW] = PW'(w_ds[k]);
    end
    for (int i = 0; i < NP; i++) begin
      ro_valid[i] = pv[i];
      ro_type[i*2 +: 2] = pt[i];
      ro_addr[i*AW +: AW] = pa[i];
      ro_data[i*DW +: DW] = pd[i];
      ri_avail[i] = av[i];
    end
  end

  pkt_xbar #(.NP(NP), .ND(ND), .AW(AW), .DW(DW), .DEF_PORT(DEF)) u_dut (
    .clk(clk), .rst_n(rst_n), .desc_en(desc_en), .desc_base(desc_base),
    .desc_limit(desc_limit), .desc_tmask(desc_tmask), .desc_dst(desc_dst),
    .ro_valid(ro_valid), .ro_type(ro_type), .ro_addr(ro_addr), .ro_data(ro_data),
    .ro_ready(ro_ready), .ri_avail(ri_avail), .ri_valid(ri_valid), .ri_type(ri_type),
    .ri_addr(ri_addr), .ri_data(ri_data), .ri_src(ri_src)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int last_d[NP];
  logic [NP-1:0] e_gnt, e_v;
  int e_src[NP];
  logic [1:0] e_t[NP];
  logic [31:0] e_a[NP], e_d[NP];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int route(int i);
    if (pt[i] == 2'b01) return last_d[i];
    if (pt[i] == 2'b11) return DEF;
    for (int k = 0; k < ND; k++)
      if (w_en[k] && w_mk[k][pt[i]] && pa[i] >= w_lo[k] && pa[i] <= w_hi[k]) return w_ds[k];
    return DEF;
  endfunction

  task automatic cycle();
    bit taken[NP];
    #1;
    e_gnt = '0;
    for (int j = 0; j < NP; j++) taken[j] = 0;
    for (int i = 0; i < NP; i++)
      if (pv[i]) begin
        int d = route(i);
        if (av[d] && !taken[d]) e_gnt[i] = 1'b1;
        taken[d] = 1;
      end
    chk("R4 R5 grant", 64'(ro_ready), 64'(e_gnt));
    e_v = '0;
    for (int i = 0; i < NP; i++)
      if (e_gnt[i]) begin
        int d = route(i);
        e_v[d] = 1'b1; e_src[d] = i; e_t[d] = pt[i]; e_a[d] = pa[i]; e_d[d] = pd[i];
      end
    @(posedge clk);
    for (int i = 0; i < NP; i++)
      if (e_gnt[i] && pt[i] == 2'b00) last_d[i] = route(i);
    @(negedge clk);
    chk("R6 lanes", 64'(ri_valid), 64'(e_v));
    for (int j = 0; j < NP; j++)
      if (e_v[j]) begin
        chk("R6 source", 64'(ri_src[j*PW +: PW]), 64'(e_src[j]));
        chk("R8 kind", 64'(ri_type[j*2 +: 2]), 64'(e_t[j]));
        chk("R8 addr", 64'(ri_addr[j*AW +: AW]), 64'(e_a[j]));
        chk("R8 data", 64'(ri_data[j*DW +: DW]), 64'(e_d[j]));
      end
    for (int i = 0; i < NP; i++) if (e_gnt[i]) pv[i] = 1'b0;
  endtask

  task automatic put(int i, logic [1:0] t, logic [31:0] a, logic [31:0] d);
    pv[i] = 1'b1; pt[i] = t; pa[i] = a; pd[i] = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] picks[12] = '{32'h0FFF, 32'h1000, 32'h17FF, 32'h1800, 32'h1FFF, 32'h2000,
                               32'h27FF, 32'h2800, 32'h3000, 32'h3FFF, 32'h4000, 32'h4FFF};
    w_en = '{1, 1, 1, 0};
    w_lo = '{32'h1000, 32'h1800, 32'h3000, 32'h4000};
    w_hi = '{32'h1FFF, 32'h27FF, 32'h3FFF, 32'h4FFF};
    w_mk = '{3'b111, 3'b111, 3'b100, 3'b111};
    w_ds = '{1, 2, 0, 2};
    for (int i = 0; i < NP; i++) begin
      pv[i] = 0; pt[i] = 0; pa[i] = 0; pd[i] = 0; av[i] = 1; last_d[i] = DEF;
    end
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 64'(ri_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 64'(ri_valid), 64'h0);

    put(3, 2'b01, 32'h1000, 32'hA1);  cycle();
    chk("R7 write before request", 64'(ri_valid), 64'b1000);
    put(2, 2'b00, 32'h1900, 32'hA2);  cycle();
    chk("R2 overlap lowest window", 64'(ri_valid), 64'b0010);
    put(0, 2'b00, 32'h3100, 32'hA3);  cycle();
    chk("R3 kind not accepted", 64'(ri_valid), 64'b1000);
    put(0, 2'b10, 32'h3100, 32'hA4);  cycle();
    chk("R2 response window", 64'(ri_valid), 64'b0001);
    put(1, 2'b00, 32'h4100, 32'hA5);  cycle();
    chk("R3 disabled window", 64'(ri_valid), 64'b1000);
    put(1, 2'b11, 32'h1000, 32'hA6);  cycle();
    chk("R3 reserved kind", 64'(ri_valid), 64'b1000);
    put(1, 2'b00, 32'h27FF, 32'hA7);  cycle();
    chk("R2 inclusive limit", 64'(ri_valid), 64'b0100);
    put(1, 2'b01, 32'h1000, 32'hA8);  cycle();
    chk("R7 write follows request", 64'(ri_valid), 64'b0100);
    chk("R8 write data", 64'(ri_data[2*DW +: DW]), 64'hA8);

    av[1] = 0;
    put(0, 2'b00, 32'h1000, 32'hB0);
    repeat (3) begin
      cycle();
      chk("R4 busy destination", 64'(ri_valid), 64'h0);
    end
    av[1] = 1; cycle();
    chk("R4 released", 64'(ri_valid), 64'b0010);

    put(0, 2'b00, 32'h1100, 32'hC0);
    put(1, 2'b00, 32'h1100, 32'hC1);
    put(2, 2'b00, 32'h1100, 32'hC2);
    for (int n = 0; n < 3; n++) begin
      cycle();
      chk("R5 rank order", 64'(ri_src[1*PW +: PW]), 64'(n));
    end

    put(0, 2'b00, 32'h1000, 32'hD0);
    put(1, 2'b00, 32'h2000, 32'hD1);
    put(2, 2'b10, 32'h3000, 32'hD2);
    put(3, 2'b00, 32'h9000, 32'hD3);
    cycle();
    chk("R9 all granted", 64'(ri_valid), 64'b1111);

    for (int c = 0; c < 3000; c++) begin
      if (c == 1500) w_en[3] = 1;
      for (int i = 0; i < NP; i++) begin
        av[i] = ($urandom_range(3) != 0);
        if (!pv[i] && $urandom_range(1) == 1)
          put(i, 2'($urandom_range(3)),
              ($urandom_range(4) == 0) ? $urandom : picks[$urandom_range(11)], $urandom);
      end
      cycle();
    end
    finish_run();
  end
endmodule